// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is the station-management master that talks to an external PHY over the two-wire MDIO bus. Software sees two 16-bit registers, a control word and a data word. Writing the control word launches exactly one clause-22 frame. The frame is a read or a write, and it targets the PHY and register selected by fields of that word. While the frame runs, a finished flag in the same register reads 0. When the frame ends, the flag returns to 1.

For a write, software first loads the data register and then writes the control word. The engine shifts out the stored value. For a read, the engine samples sixteen bits from the PHY and places them in the data register, where software collects them after it sees the finished flag. A PHY that is not present never drives the line. Because the line idles high, such a read returns all ones. MDC comes from an internal divider whose half-period is a parameter. MDIO is presented as an output value, an output enable and a sampled input, so that a pad-level tri-state buffer can be placed outside.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: Register writes use `reg_wr_sel` 0 for the control word and 1 for the data word. Control-word bit 13 is the operation (1 = write, 0 = read), bits 12:8 are the PHY address and bits 4:0 are the register number. Bits 15, 14 and 7:5 are ignored. The control readback shows the finished flag in bit 15, the operation in bit 13, the PHY address in 12:8 and the register number in 4:0, with every other bit 0.
- R2: A control-word write accepted while idle clears the finished flag (control bit 15) in the next cycle. The flag then stays 0 for exactly 128*DIV_HALF clock cycles before returning to 1.
- R3: The bits on the MDIO line at the 64 rising MDC edges of a frame are, in order:
  - 32 ones;
  - start bits 0 then 1;
  - opcode 0,1 for a write or 1,0 for a read;
  - the PHY address, MSB first;
  - the register number, MSB first;
  - two turnaround bits;
  - 16 data bits, MSB first.
- R4: During a write, the master drives MDIO for all 64 bits and sends 1 then 0 in the turnaround. During a read, it drives bits 0 to 45 and releases `mdio_oe` for the turnaround and the 16 data bits.
- R5: MDC is low whenever the engine is idle, and each MDC half-period lasts DIV_HALF clock cycles. Once a frame has started, `mdio_o` and `mdio_oe` change only in the cycle in which MDC falls.
- R6: After a read, the data register holds the 16 bits sampled on the last 16 rising MDC edges, first sample in bit 15.
- R7: A read from a PHY that never drives the line returns 16'hFFFF.
- R8: A data-word write while idle loads the data register. A write frame leaves the data register unchanged.
- R9: While a frame is in progress, writes to either register are ignored. The control fields, the data register and the frame length are unaffected.
- R10: After reset:
  - the finished flag is 1;
  - the control fields and the data register are 0;
  - MDC is low;
  - `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 = control word, 1 = data word |
| reg_wr_data | input | 16 | Value written |
| mgmt_ctrl_rd | output | 16 | Control readback with finished flag in bit 15 |
| mgmt_data_rd | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as sampled |

## Verification
The finished flag falls one cycle after the control write, so the bench samples it at the next falling system-clock edge. The bench then counts system cycles until the flag returns and expects exactly 128*DIV_HALF of them. Its PHY model changes MDIO only on MDC falling edges and records the line and the enable on each rising edge, which is a full half-period before the master could act on them. The data register and the control readback are read only in the cycle after the flag returns, because that is the first cycle in which read data is guaranteed to be in place.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam logic [5:0] TA_IDX   = 6'd46;
    localparam logic [5:0] DATA_IDX = 6'd48;
    localparam logic [5:0] LAST_IDX = 6'd63;

    // Control-word bit positions
    localparam int OP_BIT   = 13;
    localparam int DONE_BIT = 15;

    typedef struct packed {
        logic       wr;
        logic [4:0] phy;
        logic [4:0] regad;
    } mdio_cmd_t;

    function automatic mdio_cmd_t decode_ctrl(input logic [15:0] w);
        mdio_cmd_t c;
        c.wr    = w[OP_BIT];
        c.phy   = w[12:8];
        c.regad = w[4:0];
        return c;
    endfunction

    function automatic logic [15:0] encode_ctrl(input mdio_cmd_t c, input logic done);
        return {done, 1'b0, c.wr, c.phy, 3'b000, c.regad};
    endfunction

    // Serial image, first bit on the wire in bit 63
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c,
                                                           input logic [15:0] d);
        logic [1:0] opc;
        logic [1:0] ta;
        opc = c.wr ? 2'b01 : 2'b10;
        ta  = c.wr ? 2'b10 : 2'b11;
        return {32'hFFFF_FFFF, 2'b01, opc, c.phy, c.regad, ta, (c.wr ? d : 16'hFFFF)};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_HALF = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          half_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign half_end  = run && (cnt == LAST);
    assign rise_tick = half_end && !mdc;
    assign fall_tick = half_end && mdc;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic [15:0] wdata,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        finish,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    logic [FRAME_BITS-1:0] tx_sr;
    logic [15:0]           rx_sr;
    logic [5:0]            bit_idx;
    logic                  op_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            tx_sr   <= '1;
            rx_sr   <= '0;
            bit_idx <= '0;
            op_wr   <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                bit_idx <= '0;
                tx_sr   <= build_frame(cmd, wdata);
                op_wr   <= cmd.wr;
            end
        end else begin
            if (rise_tick && !op_wr && bit_idx >= DATA_IDX)
                rx_sr <= {rx_sr[14:0], mdio_i};
            if (fall_tick) begin
                if (bit_idx == LAST_IDX) begin
                    busy <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    assign finish  = busy && fall_tick && (bit_idx == LAST_IDX);
    assign mdio_o  = tx_sr[FRAME_BITS-1];
    assign mdio_oe = busy && (op_wr || bit_idx < TA_IDX);
    assign rd_data = rx_sr;

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_HALF = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic        reg_wr_sel,
    input  logic [15:0] reg_wr_data,
    output logic [15:0] mgmt_ctrl_rd,
    output logic [15:0] mgmt_data_rd,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t   cmd_q;
    logic [15:0] data_q;
    logic        busy, finish, rise_tick, fall_tick, start;
    logic [15:0] rd_data;

    assign start = reg_wr_en && !reg_wr_sel && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else if (!busy) begin
            if (reg_wr_en && !reg_wr_sel)
                cmd_q <= decode_ctrl(reg_wr_data);
            if (reg_wr_en && reg_wr_sel)
                data_q <= reg_wr_data;
        end else if (finish && !cmd_q.wr) begin
            data_q <= rd_data;
        end
    end

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (decode_ctrl(reg_wr_data)),
        .wdata     (data_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .finish    (finish),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data)
    );

    assign mgmt_ctrl_rd = encode_ctrl(cmd_q, ~busy);
    assign mgmt_data_rd = data_q;

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
    parameter int DIV_HALF = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic        reg_wr_sel,
    input logic [15:0] mgmt_ctrl_rd,
    input logic [15:0] mgmt_data_rd,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    localparam int FRAME_CYC = 128 * DIV_HALF;
    localparam int LW = $clog2(FRAME_CYC + 2);

    logic          done;
    logic [LW-1:0] len_cnt;

    assign done = mgmt_ctrl_rd[15];

    always_ff @(posedge clk) begin
        if (rst || done) len_cnt <= '0;
        else             len_cnt <= len_cnt + 1'b1;
    end

    assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (done && reg_wr_en && !reg_wr_sel) |=> !done);

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (len_cnt == LW'(FRAME_CYC)));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mdc && !mdio_oe));

    assert_edge_only_R5: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(done) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_busy_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(done)) |-> $stable(mgmt_ctrl_rd[14:0]));

    assert_busy_data_R9: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(done)) |-> $stable(mgmt_data_rd));

endmodule

bind mdio_mgmt_engine mdio_mgmt_checker #(.DIV_HALF(DIV_HALF)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_sel   (reg_wr_sel),
    .mgmt_ctrl_rd (mgmt_ctrl_rd),
    .mgmt_data_rd (mgmt_data_rd),
    .mdc          (mdc),
    .mdio_o       (mdio_o),
    .mdio_oe      (mdio_oe)
);

// File: tb/tb_mdio_mgmt_engine.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_engine;
    localparam int DIVH  = 10;
    localparam int FCYC  = 128 * DIVH;
    localparam int NVEC  = 6;

    // ctrl, wdata, phy response, phy present
    localparam logic [48:0] VEC [NVEC] = '{
        {16'h2A13, 16'hBEEF, 16'h0000, 1'b1},
        {16'h0A13, 16'h0000, 16'h1C5A, 1'b1},
        {16'h3FFF, 16'h0001, 16'h0000, 1'b1},
        {16'h40E0, 16'h5555, 16'h8000, 1'b1},
        {16'h0102, 16'h0000, 16'h1234, 1'b0},
        {16'h2000, 16'h0000, 16'hAAAA, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] mgmt_ctrl_rd, mgmt_data_rd;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_drive = 1'b1;
    wire         mdio_line = mdio_oe ? mdio_o : phy_drive;

    int checks = 0;
    int bad = 0;
    logic [15:0] cur_ctrl = '0;
    logic [15:0] cur_resp = '0;
    logic        cur_present = 1'b0;
    logic [63:0] cap_line = '0;
    logic [63:0] cap_oe = '0;
    int rcnt = 0;
    int fcnt = 0;

    always #10 clk = ~clk;

    mdio_mgmt_engine #(.DIV_HALF(DIVH)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .mgmt_ctrl_rd(mgmt_ctrl_rd),
        .mgmt_data_rd(mgmt_data_rd), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    // PHY model: record on rising MDC, drive after falling MDC
    always @(posedge mdc) begin
        cap_line[63-rcnt] = mdio_line;
        cap_oe[63-rcnt]   = mdio_oe;
        rcnt = (rcnt + 1) % 64;
    end

    always @(negedge mdc) begin
        fcnt = (fcnt + 1) % 64;
        if (!cur_ctrl[13] && cur_present && fcnt == 47)
            phy_drive = 1'b0;
        else if (!cur_ctrl[13] && cur_present && fcnt >= 48)
            phy_drive = cur_resp[63-fcnt];
        else
            phy_drive = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [63:0] exp_line(input logic [15:0] c, input logic [15:0] d,
                                             input logic [15:0] r, input logic pres);
        logic [1:0] ta;
        logic [15:0] dat;
        if (c[13]) begin ta = 2'b10; dat = d; end
        else begin ta = pres ? 2'b10 : 2'b11; dat = pres ? r : 16'hFFFF; end
        return {32'hFFFF_FFFF, 2'b01, (c[13] ? 2'b01 : 2'b10), c[12:8], c[4:0], ta, dat};
    endfunction

    // Launch a frame (data word first), wait for completion, check everything
    task automatic run_frame(input logic [15:0] c, input logic [15:0] d,
                             input logic [15:0] r, input logic pres, input bit inject);
        int cyc;
        int runlen;
        int badrun;
        logic prev;
        logic [15:0] exp_data;
        logic [15:0] exp_ctrl;
        logic [63:0] exp_oe;
        cur_ctrl = c; cur_resp = r; cur_present = pres;
        reg_write(1'b1, d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = c;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(mgmt_ctrl_rd[15] == 1'b0, "R2 flag low after launch", 64'(mgmt_ctrl_rd[15]), 64'd0);
        cyc = 0; runlen = 0; badrun = 0; prev = 1'b0;
        while (mgmt_ctrl_rd[15] == 1'b0 && cyc < 4 * FCYC) begin
            if (mdc != prev) begin
                if (runlen != DIVH) badrun++;
                runlen = 1;
                prev = mdc;
            end else runlen++;
            if (inject && cyc == 200) begin
                reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 16'h0F0F;
            end else if (inject && cyc == 201) begin
                reg_wr_sel = 1'b1; reg_wr_data = 16'h1234;
            end else if (inject && cyc == 202) begin
                reg_wr_en = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        check(cyc == FCYC, "R2 frame length", 64'(cyc), 64'(FCYC));
        check(badrun == 0, "R5 mdc half period", 64'(badrun), 64'd0);
        check(cap_line == exp_line(c, d, r, pres), "R3 frame bits", cap_line,
              exp_line(c, d, r, pres));
        exp_oe = c[13] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000;
        check(cap_oe == exp_oe, "R4 drive enable", cap_oe, exp_oe);
        exp_data = c[13] ? d : (pres ? r : 16'hFFFF);
        check(mgmt_data_rd == exp_data, c[13] ? "R8 data kept" : (pres ? "R6 read data" : "R7 absent phy"),
              64'(mgmt_data_rd), 64'(exp_data));
        exp_ctrl = {1'b1, 1'b0, c[13], c[12:8], 3'b000, c[4:0]};
        check(mgmt_ctrl_rd == exp_ctrl, inject ? "R9 ctrl write ignored" : "R1 ctrl fields",
              64'(mgmt_ctrl_rd), 64'(exp_ctrl));
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R5 idle quiet", {mdc, mdio_oe}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(mgmt_ctrl_rd == 16'h8000, "R10 ctrl reset", 64'(mgmt_ctrl_rd), 64'h8000);
        check(mgmt_data_rd == 16'h0000, "R10 data reset", 64'(mgmt_data_rd), 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 pins reset", {mdc, mdio_oe}, 64'd0);

        // R8 data write while idle
        reg_write(1'b1, 16'hC3A5);
        @(negedge clk);
        check(mgmt_data_rd == 16'hC3A5, "R8 data load", 64'(mgmt_data_rd), 64'hC3A5);

        for (int i = 0; i < NVEC; i++)
            run_frame(VEC[i][48:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0], 1'b0);

        // R9: writes during a write frame are dropped
        run_frame(16'h2522, 16'h6789, 16'h0000, 1'b1, 1'b1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule